// File: doc/BRIEF.md
# Keyed-Hash Memory Bus Encryptor

This unit sits between a 16-bit processor and a plain binary SRAM and hides stored data behind an address-dependent mask. Four configurable address regions each hold a 64-bit key. When an access falls in a region, a four-round substitution hash of the word address under that region's key yields a 16-bit pad. Written data is XORed with the pad before it reaches the SRAM. Read data is XORed with the same pad on its way back. The pad for a read is formed while the SRAM access is in flight. An address that lies in no enabled region passes straight through with no masking.

A region can be flagged so that each word in it accepts only one write. A second write to the same word is blocked and reported. This stops repeated plaintext at one address from producing repeated ciphertext. A region's key can be erased after use. Any later access to that region, or to an enabled region that was never keyed, is refused, and a refused read returns zero. Regions are set up one field at a time through a small configuration port.

Top module: `busCrypt`

## Requirements
- R1: A request accepted at a rising edge reaches the SRAM (memEn high) in the next cycle and is acknowledged (cpuAck high) exactly two cycles after acceptance; one request can be accepted every cycle.
- R2: The pad is a four-round hash of the 16-bit zero-extended word address. Round r uses key bits [16r+15:16r]. Output nibble j of a round is the XOR over input nibbles i of S(in_i XOR key_j), where nibble n occupies bits [4n+3:4n]. S maps 0..F to 3,8,F,1,A,6,5,B,E,D,4,2,7,0,9,C. The pad is the output of round 3.
- R3: A write that hits a region stores writeData XOR pad at the same SRAM address.
- R4: A read that hits a region returns the SRAM word XOR pad.
- R5: An access that hits no enabled region writes and reads the SRAM word unchanged.
- R6: Region bounds are inclusive (base <= addr <= limit). When regions overlap, the lowest-numbered matching region supplies the key.
- R7: In a region flagged write-once, the first write to a word proceeds. Any later write to that word, including one issued in the very next cycle, does not reach the SRAM and is acknowledged with cpuErr high. Reads of the word are unaffected.
- R8: An access to an enabled region whose key is erased, or was never loaded, is acknowledged with cpuErr high. Such a write does not reach the SRAM, and such a read returns 0.
- R9: A configuration write takes effect for requests accepted at later edges. A request accepted at the same edge as a key erase still uses the old key and succeeds.
- R10: After reset, all regions are disabled and unkeyed, no word is marked written, and cpuAck and memEn are low.
- R11: Configuration items on cfgItem are: 0 base, 1 limit (cfgData[ADDR_W-1:0]), 2..5 key bits [15:0], [31:16], [47:32] and [63:48] (each one marks the key loaded), 6 flags (cfgData[0] enable, cfgData[1] write-once), and 7 erase the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request valid |
| cpuWe | input | 1 | Request is a write |
| cpuAddr | input | ADDR_W | Processor word address |
| cpuWdata | input | 16 | Processor write data |
| cpuRdata | output | 16 | Unmasked read data, valid with cpuAck |
| cpuAck | output | 1 | Request completed |
| cpuErr | output | 1 | Request refused (write-once or missing key) |
| memEn | output | 1 | SRAM access enable |
| memWe | output | 1 | SRAM write enable |
| memAddr | output | ADDR_W | SRAM address |
| memWdata | output | 16 | Masked SRAM write data |
| memRdata | input | 16 | SRAM read data, one cycle after memEn |
| cfgWe | input | 1 | Configuration write strobe |
| cfgRegion | input | 2 | Region being configured |
| cfgItem | input | 3 | Configuration item selector |
| cfgData | input | 16 | Configuration value |

## Verification
Two pairs of functions can collide in a single cycle. The first pair is a key erase and an access to the region being erased. The bench drives the erase and a read of that region at the same edge. It expects the read to succeed with the old key, and the read that follows to fail with zero data. The second pair is marking a word written and checking a new write to that word. Two writes to one write-once word are issued back to back. The second must be refused, and the SRAM must still hold the first ciphertext.

// File: rtl/busCryptPkg.sv
package busCryptPkg;

  typedef struct packed {
    logic cap1;     // capture pad and write data for a new request
    logic cipher1;  // stage-1 request is masked
    logic cap2;     // advance pad into response stage
    logic cipher2;  // stage-2 response is masked
    logic pass2;    // stage-2 read data is delivered
  } cryptStrb_t;

  typedef enum logic [2:0] {
    CFG_BASE  = 3'd0,
    CFG_LIMIT = 3'd1,
    CFG_KEY0  = 3'd2,
    CFG_KEY1  = 3'd3,
    CFG_KEY2  = 3'd4,
    CFG_KEY3  = 3'd5,
    CFG_FLAGS = 3'd6,
    CFG_ERASE = 3'd7
  } cfgItem_t;

  function automatic logic [3:0] subNibble(input logic [3:0] v);
    case (v)
      4'h0: subNibble = 4'h3;
      4'h1: subNibble = 4'h8;
      4'h2: subNibble = 4'hF;
      4'h3: subNibble = 4'h1;
      4'h4: subNibble = 4'hA;
      4'h5: subNibble = 4'h6;
      4'h6: subNibble = 4'h5;
      4'h7: subNibble = 4'hB;
      4'h8: subNibble = 4'hE;
      4'h9: subNibble = 4'hD;
      4'hA: subNibble = 4'h4;
      4'hB: subNibble = 4'h2;
      4'hC: subNibble = 4'h7;
      4'hD: subNibble = 4'h0;
      4'hE: subNibble = 4'h9;
      default: subNibble = 4'hC;
    endcase
  endfunction

endpackage

// File: rtl/padHash.sv
module padHash #(
  parameter int ROUNDS = 4,
  localparam int WORD_W = 16,
  localparam int NIBS = WORD_W / 4,
  localparam int KEY_W = ROUNDS * WORD_W
) (
  input  logic [WORD_W-1:0] seed,
  input  logic [KEY_W-1:0]  key,
  output logic [WORD_W-1:0] pad
);
  import busCryptPkg::*;

  logic [ROUNDS:0][WORD_W-1:0] roundVal;

  assign roundVal[0] = seed;

  for (genvar r = 0; r < ROUNDS; r++) begin : gRound
    for (genvar j = 0; j < NIBS; j++) begin : gOut
      logic [3:0] keyNib;
      logic [3:0] mixNib;
      assign keyNib = key[r*WORD_W + 4*j +: 4];
      always_comb begin
        mixNib = '0;
        for (int i = 0; i < NIBS; i++) begin
          mixNib = mixNib ^ subNibble(roundVal[r][4*i +: 4] ^ keyNib);
        end
      end
      assign roundVal[r+1][4*j +: 4] = mixNib;
    end
  end

  assign pad = roundVal[ROUNDS];

endmodule

// File: rtl/encData.sv
module encData #(
  parameter int ADDR_W = 8,
  parameter int ROUNDS = 4,
  localparam int WORD_W = 16,
  localparam int KEY_W = ROUNDS * WORD_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  busCryptPkg::cryptStrb_t    strb,
  input  logic [ADDR_W-1:0]          cpuAddr,
  input  logic [KEY_W-1:0]           selKey,
  input  logic [WORD_W-1:0]          cpuWdata,
  input  logic [WORD_W-1:0]          memRdata,
  output logic [WORD_W-1:0]          memWdata,
  output logic [WORD_W-1:0]          cpuRdata
);
  logic [WORD_W-1:0] padNow;
  logic [WORD_W-1:0] s1Pad;
  logic [WORD_W-1:0] s1Wdata;
  logic [WORD_W-1:0] s2Pad;

  padHash #(.ROUNDS(ROUNDS)) hash_i (
    .seed(WORD_W'(cpuAddr)),
    .key (selKey),
    .pad (padNow)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Pad   <= '0;
      s1Wdata <= '0;
      s2Pad   <= '0;
    end else begin
      if (strb.cap1) begin
        s1Pad   <= padNow;
        s1Wdata <= cpuWdata;
      end
      if (strb.cap2) s2Pad <= s1Pad;
    end
  end

  assign memWdata = strb.cipher1 ? (s1Wdata ^ s1Pad) : s1Wdata;

  always_comb begin
    if (!strb.pass2)       cpuRdata = '0;
    else if (strb.cipher2) cpuRdata = memRdata ^ s2Pad;
    else                   cpuRdata = memRdata;
  end

endmodule

// File: rtl/encCtrl.sv
module encCtrl #(
  parameter int ADDR_W = 8,
  parameter int REGIONS = 4,
  parameter int ROUNDS = 4,
  localparam int IDX_W = $clog2(REGIONS),
  localparam int KEY_W = ROUNDS * 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cpuReq,
  input  logic                     cpuWe,
  input  logic [ADDR_W-1:0]        cpuAddr,
  input  logic                     cfgWe,
  input  logic [IDX_W-1:0]         cfgRegion,
  input  logic [2:0]               cfgItem,
  input  logic [15:0]              cfgData,
  output logic [KEY_W-1:0]         selKey,
  output busCryptPkg::cryptStrb_t  strb,
  output logic                     memEn,
  output logic                     memWe,
  output logic [ADDR_W-1:0]        memAddr,
  output logic                     cpuAck,
  output logic                     cpuErr
);
  import busCryptPkg::*;

  // region table
  logic [ADDR_W-1:0] regBase  [REGIONS];
  logic [ADDR_W-1:0] regLimit [REGIONS];
  logic [KEY_W-1:0]  regKey   [REGIONS];
  logic [REGIONS-1:0] regOn, regOnce, regKeyed;

  // per-word written marks
  logic [DEPTH-1:0] written;

  // decode of the incoming address
  logic             hit0;
  logic [IDX_W-1:0] hitIdx;

  // stage 1: SRAM access
  logic              s1Valid, s1We, s1Hit, s1Once, s1Keyed;
  logic [ADDR_W-1:0] s1Addr;
  logic              blocked1, markOnce;

  // stage 2: response
  logic s2Valid, s2We, s2Hit, s2Err;

  int keyPart;
  assign keyPart = int'(cfgItem) - int'(CFG_KEY0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int g = 0; g < REGIONS; g++) begin
        regBase[g]  <= '0;
        regLimit[g] <= '0;
        regKey[g]   <= '0;
      end
      regOn    <= '0;
      regOnce  <= '0;
      regKeyed <= '0;
    end else if (cfgWe) begin
      case (cfgItem_t'(cfgItem))
        CFG_BASE:  regBase[cfgRegion]  <= cfgData[ADDR_W-1:0];
        CFG_LIMIT: regLimit[cfgRegion] <= cfgData[ADDR_W-1:0];
        CFG_KEY0, CFG_KEY1, CFG_KEY2, CFG_KEY3: begin
          if (keyPart < ROUNDS) begin
            regKey[cfgRegion][16*keyPart +: 16] <= cfgData;
            regKeyed[cfgRegion] <= 1'b1;
          end
        end
        CFG_FLAGS: begin
          regOn[cfgRegion]   <= cfgData[0];
          regOnce[cfgRegion] <= cfgData[1];
        end
        default: begin
          regKey[cfgRegion]   <= '0;
          regKeyed[cfgRegion] <= 1'b0;
        end
      endcase
    end
  end

  // lowest-numbered matching region wins: scan from the top down
  always_comb begin
    hit0   = 1'b0;
    hitIdx = '0;
    for (int g = REGIONS - 1; g >= 0; g--) begin
      if (regOn[g] && (cpuAddr >= regBase[g]) && (cpuAddr <= regLimit[g])) begin
        hit0   = 1'b1;
        hitIdx = IDX_W'(g);
      end
    end
  end

  assign selKey = regKey[hitIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1We    <= 1'b0;
      s1Hit   <= 1'b0;
      s1Once  <= 1'b0;
      s1Keyed <= 1'b0;
      s1Addr  <= '0;
      s2Valid <= 1'b0;
      s2We    <= 1'b0;
      s2Hit   <= 1'b0;
      s2Err   <= 1'b0;
    end else begin
      s1Valid <= cpuReq;
      if (cpuReq) begin
        s1We    <= cpuWe;
        s1Hit   <= hit0;
        s1Once  <= regOnce[hitIdx];
        s1Keyed <= regKeyed[hitIdx];
        s1Addr  <= cpuAddr;
      end
      s2Valid <= s1Valid;
      if (s1Valid) begin
        s2We  <= s1We;
        s2Hit <= s1Hit;
        s2Err <= blocked1;
      end
    end
  end

  assign blocked1 = s1Hit && (!s1Keyed || (s1We && s1Once && written[s1Addr]));
  assign markOnce = s1Valid && s1We && s1Hit && s1Once && !blocked1;

  always_ff @(posedge clk) begin
    if (!rstN)         written <= '0;
    else if (markOnce) written[s1Addr] <= 1'b1;
  end

  assign memEn   = s1Valid && !blocked1;
  assign memWe   = s1We;
  assign memAddr = s1Addr;
  assign cpuAck  = s2Valid;
  assign cpuErr  = s2Valid && s2Err;

  always_comb begin
    strb         = '0;
    strb.cap1    = cpuReq;
    strb.cipher1 = s1Hit;
    strb.cap2    = s1Valid;
    strb.cipher2 = s2Hit;
    strb.pass2   = s2Valid && !s2We && !s2Err;
  end

  // R1: fixed two-cycle response
  assert_ack_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq |-> ##2 cpuAck);

  // R1: an SRAM access is followed by a clean acknowledge
  assert_access_ok_R1: assert property (@(posedge clk) disable iff (!rstN)
    memEn |=> (cpuAck && !cpuErr));

  // R7: a completed write in a write-once region leaves its word marked
  assert_once_marked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe && s1Hit && s1Once) |=> written[$past(memAddr)]);

  // R8: an erase leaves the region unkeyed
  assert_erase_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgItem == CFG_ERASE) |=> !regKeyed[$past(cfgRegion)]);

endmodule

// File: rtl/busCrypt.sv
module busCrypt #(
  parameter int ADDR_W = 8,
  parameter int REGIONS = 4,
  parameter int ROUNDS = 4,
  localparam int IDX_W = $clog2(REGIONS),
  localparam int KEY_W = ROUNDS * 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [15:0]       cpuWdata,
  output logic [15:0]       cpuRdata,
  output logic              cpuAck,
  output logic              cpuErr,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWdata,
  input  logic [15:0]       memRdata,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgRegion,
  input  logic [2:0]        cfgItem,
  input  logic [15:0]       cfgData
);
  import busCryptPkg::*;

  cryptStrb_t       strb;
  logic [KEY_W-1:0] selKey;

  encCtrl #(.ADDR_W(ADDR_W), .REGIONS(REGIONS), .ROUNDS(ROUNDS)) ctrl_i (
    .clk, .rstN, .cpuReq, .cpuWe, .cpuAddr,
    .cfgWe, .cfgRegion, .cfgItem, .cfgData,
    .selKey, .strb, .memEn, .memWe, .memAddr, .cpuAck, .cpuErr
  );

  encData #(.ADDR_W(ADDR_W), .ROUNDS(ROUNDS)) data_i (
    .clk, .rstN, .strb, .cpuAddr, .selKey, .cpuWdata, .memRdata,
    .memWdata, .cpuRdata
  );

  // R8: a refused access never hands back data
  assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAck && cpuErr) |-> (cpuRdata == '0));

endmodule

// File: tb/busCrypt_tb_top.sv
module busCrypt_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 1'b0, cpuWe = 1'b0;
  logic [7:0] cpuAddr = '0;
  logic [15:0] cpuWdata = '0;
  logic [15:0] cpuRdata;
  logic cpuAck, cpuErr, memEn, memWe;
  logic [7:0] memAddr;
  logic [15:0] memWdata;
  logic [15:0] memRdata = '0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgRegion = '0;
  logic [2:0] cfgItem = '0;
  logic [15:0] cfgData = '0;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  busCrypt dut_i (
    .clk, .rstN, .cpuReq, .cpuWe, .cpuAddr, .cpuWdata, .cpuRdata, .cpuAck, .cpuErr,
    .memEn, .memWe, .memAddr, .memWdata, .memRdata,
    .cfgWe, .cfgRegion, .cfgItem, .cfgData
  );

  // SRAM model
  logic [15:0] sram [256];
  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) sram[memAddr] <= memWdata;
      else       memRdata <= sram[memAddr];
    end
  end

  // reference pad from R2
  logic [3:0] sbTab [16] = '{4'h3,4'h8,4'hF,4'h1,4'hA,4'h6,4'h5,4'hB,
                             4'hE,4'hD,4'h4,4'h2,4'h7,4'h0,4'h9,4'hC};
  function automatic logic [15:0] refPad(input logic [63:0] k, input logic [7:0] a);
    logic [15:0] x, y;
    x = {8'h00, a};
    for (int r = 0; r < 4; r++) begin
      y = '0;
      for (int j = 0; j < 4; j++)
        for (int i = 0; i < 4; i++)
          y[4*j +: 4] = y[4*j +: 4] ^ sbTab[x[4*i +: 4] ^ k[16*r + 4*j +: 4]];
      x = y;
    end
    return x;
  endfunction

  localparam logic [63:0] K0 = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] K1 = 64'hFEDC_BA98_7654_3210;
  localparam logic [63:0] K2 = 64'h0F1E_2D3C_4B5A_6978;

  typedef struct {
    bit          isRd;
    bit          err;
    logic [15:0] data;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && cpuAck) begin
      if (expQ.size() == 0) begin
        chk("R1 unexpected ack", 16'd1, 16'd0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        chk({e.tag, " err"}, {15'd0, cpuErr}, {15'd0, e.err});
        if (e.isRd) chk({e.tag, " rdata"}, cpuRdata, e.data);
      end
    end
  end

  task automatic drive(input bit we, input logic [7:0] a, input logic [15:0] d,
                       input bit eErr, input logic [15:0] eData, input string tag);
    expItem_t e;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = d;
    e.isRd = !we; e.err = eErr; e.data = eData; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    cpuReq = 1'b0; cfgWe = 1'b0;
  endtask

  task automatic settle();
    idle();
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] rg, input logic [2:0] item, input logic [15:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgRegion = rg; cfgItem = item; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setRegion(input logic [1:0] rg, input logic [7:0] lo, input logic [7:0] hi,
                           input logic [63:0] k, input bit withKey, input bit once);
    cfg(rg, 3'd0, {8'h00, lo});
    cfg(rg, 3'd1, {8'h00, hi});
    if (withKey) for (int q = 0; q < 4; q++) cfg(rg, 3'(2 + q), k[16*q +: 16]);
    cfg(rg, 3'd6, {14'd0, once, 1'b1});
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 256; m++) sram[m] = 16'h0000;
    sram[8'h10] = 16'h3C3C;
    sram[8'h26] = 16'hBEEF;
    sram[8'h31] = 16'h7777;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 ack after reset", {15'd0, cpuAck}, 16'd0);
    chk("R10 memEn after reset", {15'd0, memEn}, 16'd0);
    // R10/R5 no region active: raw pass-through
    drive(1'b0, 8'h10, 16'h0, 1'b0, 16'h3C3C, "R10 read with regions off");
    // R1 latency
    @(negedge clk);
    cpuReq = 1'b0;
    chk("R1 memEn one cycle after request", {15'd0, memEn}, 16'd1);
    chk("R1 no ack one cycle after request", {15'd0, cpuAck}, 16'd0);
    @(negedge clk);
    chk("R1 ack two cycles after request", {15'd0, cpuAck}, 16'd1);
    settle();

    // R5 pass-through write
    drive(1'b1, 8'h05, 16'h1234, 1'b0, 16'h0, "R5 plain write");
    settle();
    chk("R5 plain word stored", sram[8'h05], 16'h1234);

    // regions: 0 = 10..1F K0, 1 = 18..30 K1, 2 = 40..4F K2 write-once, 3 = 60..6F unkeyed
    setRegion(2'd0, 8'h10, 8'h1F, K0, 1'b1, 1'b0);
    setRegion(2'd1, 8'h18, 8'h30, K1, 1'b1, 1'b0);
    setRegion(2'd2, 8'h40, 8'h4F, K2, 1'b1, 1'b1);
    setRegion(2'd3, 8'h60, 8'h6F, 64'h0, 1'b0, 1'b0);

    // R3/R4/R2
    drive(1'b1, 8'h12, 16'hA5C3, 1'b0, 16'h0, "R3 masked write");
    drive(1'b0, 8'h12, 16'h0, 1'b0, 16'hA5C3, "R4 masked read back");
    drive(1'b0, 8'h13, 16'h0, 1'b0, refPad(K0, 8'h13), "R2 pad of zero word");
    drive(1'b0, 8'h10, 16'h0, 1'b0, 16'h3C3C ^ refPad(K0, 8'h10), "R6 lower bound inclusive");
    drive(1'b0, 8'h31, 16'h0, 1'b0, 16'h7777, "R5 just above region");
    drive(1'b1, 8'h18, 16'h1111, 1'b0, 16'h0, "R6 overlap write");
    drive(1'b1, 8'h25, 16'h5A5A, 1'b0, 16'h0, "R6 second region write");
    settle();
    chk("R3 ciphertext in SRAM", sram[8'h12], 16'hA5C3 ^ refPad(K0, 8'h12));
    chk("R6 overlap uses region 0", sram[8'h18], 16'h1111 ^ refPad(K0, 8'h18));
    chk("R6 region 1 key", sram[8'h25], 16'h5A5A ^ refPad(K1, 8'h25));
    drive(1'b0, 8'h30, 16'h0, 1'b0, refPad(K1, 8'h30), "R6 upper bound inclusive");

    // R7 write-once, back-to-back
    drive(1'b1, 8'h41, 16'hAAAA, 1'b0, 16'h0, "R7 first write");
    drive(1'b1, 8'h41, 16'h5555, 1'b1, 16'h0, "R7 back-to-back rewrite");
    drive(1'b0, 8'h41, 16'h0, 1'b0, 16'hAAAA, "R7 read after block");
    drive(1'b1, 8'h42, 16'h0F0F, 1'b0, 16'h0, "R7 other word");
    settle();
    chk("R7 SRAM keeps first ciphertext", sram[8'h41], 16'hAAAA ^ refPad(K2, 8'h41));
    drive(1'b1, 8'h42, 16'hFFFF, 1'b1, 16'h0, "R7 late rewrite");
    settle();
    chk("R7 late rewrite left word", sram[8'h42], 16'h0F0F ^ refPad(K2, 8'h42));

    // R9 erase in same cycle as read, R8 afterwards
    drive(1'b0, 8'h25, 16'h0, 1'b0, 16'h5A5A, "R9 read same cycle as erase");
    cfgWe = 1'b1; cfgRegion = 2'd1; cfgItem = 3'd7; cfgData = 16'h0;
    drive(1'b0, 8'h25, 16'h0, 1'b1, 16'h0, "R8 read after erase");
    cfgWe = 1'b0;
    drive(1'b1, 8'h26, 16'h0001, 1'b1, 16'h0, "R8 write after erase");
    drive(1'b0, 8'h61, 16'h0, 1'b1, 16'h0, "R8 never keyed region");
    drive(1'b0, 8'h12, 16'h0, 1'b0, 16'hA5C3, "R11 other region unaffected");
    settle();
    chk("R8 blocked write left SRAM", sram[8'h26], 16'hBEEF);
    chk("R1 all responses seen", 16'(expQ.size()), 16'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule